// File: doc/BRIEF.md
# Transmit Descriptor Ring Controller

This block sends data from a circular list of transmit descriptors that sit in a small on-chip RAM. Each descriptor is eight bytes long. It holds a 16-bit status/control word, a 16-bit byte count and a 32-bit buffer address. Starting from a base address, the controller reads each descriptor in turn. When it finds one marked ready, it streams that buffer's bytes to a byte-wide synchronous serial transmitter through a valid/ready handshake. At the end of a block it can append a check sequence or filler characters.

When a buffer is finished, the controller writes the status word back once. That write hands the descriptor back to software unless the descriptor asked to be kept for automatic resending. The controller also pulses a completion event or an error event, and then moves on to the next descriptor. A wrap flag in a descriptor sends the walk back to the base address.

The check-sequence arithmetic lives outside this block. The controller tells the external engine which bytes to fold in, reads its 16-bit result and tells it when to clear. If the RAM is busy at the moment the transmitter wants the next byte of a buffer, the buffer is abandoned and flagged as an underrun.

Top module: `txr_desc_ring`

## Requirements
- R1: A descriptor whose status bit 15 (ready) is 0 sends no byte. The controller keeps re-reading the status word at that same descriptor address until the bit is found set.
- R2: A ready descriptor sends exactly length bytes, starting at the buffer address and going up in order. A byte at an even RAM address is bits 15:8 of its 16-bit word, and a byte at an odd address is bits 7:0.
- R3: After a descriptor is closed, the next status read is at the base address when status bit 13 (wrap) was 1. Otherwise it is at the closed descriptor's address plus 8.
- R4: The written-back status word keeps all control bits and has bit 15 cleared. The exception is status bit 9 (continuous) set with no underrun: then bit 15 stays 1 and the same buffer is sent again on the next visit.
- R5: With status bit 11 (last) and bit 10 (check) both 1, two more bytes follow the data: crc_val[15:8] and then crc_val[7:0]. crc_upd pulses for each accepted data byte and for nothing else. crc_clr pulses once after the second check byte is accepted.
- R6: With bit 11 = 1 and bit 10 = 0, the data is followed by syn1 and then syn2 when idle_sel is 0, and by one 8'hFF idle byte when idle_sel is 1. With bit 11 = 0 nothing is appended, whatever the value of bit 10.
- R7: With status bit 12 (interrupt) set, ev_tx pulses for one cycle right after a write-back that reports no underrun, and ev_txe pulses instead when an underrun is reported. With bit 12 clear, neither pulses. The two never pulse together.
- R8: If, partway through a buffer, tx_ready is 1 while the RAM refuses the next byte read (mem_gnt = 0), the buffer is abandoned. Status bit 1 (underrun) is set, bit 15 is cleared and the walk moves on. In every other case the written-back bit 1 is 0.
- R9: Each descriptor is closed by exactly one 16-bit write, to its own status address. That write happens only after every byte of the buffer and its tail has been accepted, so tx_valid is low during the write.
- R10: Once tx_valid is raised, it and tx_data stay unchanged until tx_ready is seen high at a clock edge.
- R11: During and right after reset, tx_valid, ev_tx and ev_txe are 0. The first RAM read is the status word at base_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | AW | RAM byte address of the first descriptor |
| idle_sel | input | 1 | Block filler choice: 0 = two sync characters, 1 = one idle character |
| syn1 | input | 8 | First sync character |
| syn2 | input | 8 | Second sync character |
| mem_req | output | 1 | RAM access request |
| mem_we | output | 1 | RAM access is a write |
| mem_addr | output | AW | RAM byte address (always even) |
| mem_wdata | output | 16 | RAM write data |
| mem_gnt | input | 1 | RAM accepts the request this cycle; read data follows one cycle later |
| mem_rdata | input | 16 | RAM read data |
| tx_data | output | 8 | Byte to the transmitter |
| tx_valid | output | 1 | tx_data holds a byte |
| tx_ready | input | 1 | Transmitter takes a byte |
| crc_upd | output | 1 | Fold tx_data into the check engine |
| crc_clr | output | 1 | Clear the check engine |
| crc_val | input | 16 | Current check engine result |
| ev_tx | output | 1 | Buffer finished without error (one-cycle pulse) |
| ev_txe | output | 1 | Buffer ended by underrun (one-cycle pulse) |

## Verification
The assertions check on every cycle the properties that hold at any moment. These are the stream handshake stability, the exclusive events that follow a write-back, and a write-back that only happens with the stream drained and at the current descriptor's address. They also cover the next-descriptor address after a close (wrap or plus eight), that a byte is only sent from a descriptor found ready, and that a check-engine clear follows an accepted byte.

Only the bench scenarios can show the actual byte content and order. That covers big-endian byte selection from an odd start address, the check bytes and sync/idle fillers, the exact status value written back and resending under continuous mode. It also covers polling of an unready descriptor and the underrun path caused by a withheld RAM grant.

// File: rtl/txr_pkg.sv
package txr_pkg;

  // Status word bit positions; software decodes them, so they are fixed.
  localparam int ST_RDY  = 15;
  localparam int ST_WRAP = 13;
  localparam int ST_INT  = 12;
  localparam int ST_LAST = 11;
  localparam int ST_CHK  = 10;
  localparam int ST_CONT = 9;
  localparam int ST_UNDR = 1;

  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    S_INIT,
    S_RD,
    S_DATA,
    S_PRES,
    S_TAIL,
    S_WB
  } txr_state_e;

  // Status value written back when a descriptor is closed.
  function automatic logic [15:0] closed_status(input logic [15:0] st, input logic undr);
    logic [15:0] s;
    s          = st;
    s[ST_RDY]  = st[ST_CONT] & ~undr;
    s[ST_UNDR] = undr;
    return s;
  endfunction

  // Big-endian byte lane selection inside a 16-bit word.
  function automatic logic [7:0] pick_byte(input logic [15:0] w, input logic odd);
    return odd ? w[7:0] : w[15:8];
  endfunction

endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int AW   = 12,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= base;
    else if (adv)  cur <= wrap ? base : cur + STEP_V;
  end
endmodule

// File: rtl/txr_tail_gen.sv
module txr_tail_gen #(
  parameter logic [7:0] IDLE_CHAR = 8'hFF
) (
  input  logic        last,
  input  logic        chk_en,
  input  logic        idle_sel,
  input  logic [7:0]  syn1,
  input  logic [7:0]  syn2,
  input  logic [15:0] chk,
  input  logic [1:0]  sel,
  output logic [1:0]  count,
  output logic [7:0]  tbyte,
  output logic        is_chk
);
  always_comb begin
    is_chk = last & chk_en;
    if (!last)         count = 2'd0;
    else if (chk_en)   count = 2'd2;
    else if (idle_sel) count = 2'd1;
    else               count = 2'd2;

    if (chk_en)        tbyte = (sel == 2'd0) ? chk[15:8] : chk[7:0];
    else if (idle_sel) tbyte = IDLE_CHAR;
    else               tbyte = (sel == 2'd0) ? syn1 : syn2;
  end
endmodule

// File: rtl/txr_desc_ring.sv
module txr_desc_ring #(
  parameter int         AW        = 12,
  parameter int         LEN_W     = 16,
  parameter logic [7:0] IDLE_CHAR = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic          idle_sel,
  input  logic [7:0]    syn1,
  input  logic [7:0]    syn2,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [15:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          crc_upd,
  output logic          crc_clr,
  input  logic [15:0]   crc_val,
  output logic          ev_tx,
  output logic          ev_txe
);
  import txr_pkg::*;

  txr_state_e       state;
  logic [15:0]      st;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] idx;
  logic [AW-1:0]    bptr;
  logic [1:0]       rd_sel;
  logic             pend;
  logic [1:0]       tidx;
  logic             undr;

  // Named internal events, brought out for the checker.
  logic [AW-1:0] desc_addr;
  logic          wb_fire;
  logic          wrap_now;
  logic          st_ready;
  logic [AW-1:0] byte_addr;
  logic [1:0]    tail_cnt;
  logic [7:0]    tail_byte;
  logic          tail_chk;
  logic          buf_done;

  assign wb_fire   = (state == S_WB) && mem_gnt;
  assign wrap_now  = st[ST_WRAP];
  assign st_ready  = st[ST_RDY];
  assign byte_addr = bptr + idx[AW-1:0];
  assign buf_done  = (idx == len);

  txr_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (state == S_INIT),
    .adv   (wb_fire),
    .wrap  (wrap_now),
    .base  (base_addr),
    .cur   (desc_addr)
  );

  txr_tail_gen #(.IDLE_CHAR(IDLE_CHAR)) u_tail (
    .last     (st[ST_LAST]),
    .chk_en   (st[ST_CHK]),
    .idle_sel (idle_sel),
    .syn1     (syn1),
    .syn2     (syn2),
    .chk      (crc_val),
    .sel      (tidx),
    .count    (tail_cnt),
    .tbyte    (tail_byte),
    .is_chk   (tail_chk)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_RD: begin
        mem_req  = !pend;
        mem_addr = desc_addr + AW'({rd_sel, 1'b0});
      end
      S_DATA: begin
        mem_req  = !pend && !buf_done;
        mem_addr = {byte_addr[AW-1:1], 1'b0};
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr;
        mem_wdata = closed_status(st, undr);
      end
      default: ;
    endcase
  end

  assign crc_upd = (state == S_PRES) && tx_valid && tx_ready;
  assign crc_clr = (state == S_TAIL) && !tx_valid && (tidx == tail_cnt) && tail_chk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_INIT;
      st       <= '0;
      len      <= '0;
      idx      <= '0;
      bptr     <= '0;
      rd_sel   <= '0;
      pend     <= 1'b0;
      tidx     <= '0;
      undr     <= 1'b0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      ev_tx    <= 1'b0;
      ev_txe   <= 1'b0;
    end else begin
      ev_tx  <= wb_fire && st[ST_INT] && !undr;
      ev_txe <= wb_fire && st[ST_INT] && undr;
      unique case (state)
        S_INIT: begin
          state  <= S_RD;
          rd_sel <= '0;
          pend   <= 1'b0;
        end
        S_RD: begin
          if (!pend) begin
            if (mem_gnt) pend <= 1'b1;
          end else begin
            pend <= 1'b0;
            unique case (rd_sel)
              2'd0: begin
                st <= mem_rdata;
                if (mem_rdata[ST_RDY]) rd_sel <= 2'd1;
              end
              2'd1: begin
                len    <= mem_rdata[LEN_W-1:0];
                rd_sel <= 2'd2;
              end
              2'd2: rd_sel <= 2'd3;
              default: begin
                bptr   <= mem_rdata[AW-1:0];
                idx    <= '0;
                undr   <= 1'b0;
                rd_sel <= 2'd0;
                state  <= S_DATA;
              end
            endcase
          end
        end
        S_DATA: begin
          if (buf_done) begin
            tidx  <= '0;
            state <= S_TAIL;
          end else if (!pend) begin
            if (mem_gnt) pend <= 1'b1;
            else if (tx_ready && idx != '0) begin
              undr  <= 1'b1;
              state <= S_WB;
            end
          end else begin
            pend     <= 1'b0;
            tx_data  <= pick_byte(mem_rdata, byte_addr[0]);
            tx_valid <= 1'b1;
            state    <= S_PRES;
          end
        end
        S_PRES: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            idx      <= idx + 1'b1;
            state    <= S_DATA;
          end
        end
        S_TAIL: begin
          if (tx_valid) begin
            if (tx_ready) begin
              tx_valid <= 1'b0;
              tidx     <= tidx + 1'b1;
            end
          end else if (tidx == tail_cnt) begin
            state <= S_WB;
          end else begin
            tx_data  <= tail_byte;
            tx_valid <= 1'b1;
          end
        end
        S_WB: begin
          if (mem_gnt) begin
            rd_sel <= '0;
            pend   <= 1'b0;
            state  <= S_RD;
          end
        end
        default: state <= S_INIT;
      endcase
    end
  end
endmodule

// File: rtl/txr_desc_ring_chk.sv
module txr_desc_ring_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] base_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          crc_clr,
  input logic          ev_tx,
  input logic          ev_txe,
  input logic [AW-1:0] desc_addr,
  input logic          wb_fire,
  input logic          wrap_now,
  input logic          st_ready
);
  localparam logic [AW-1:0] STEP_V = AW'(8);

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R10

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_tx && ev_txe)); // R7

  AST_EVENT_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx || ev_txe) |-> $past(wb_fire)); // R7

  AST_CLOSE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> !tx_valid); // R9

  AST_CLOSE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr == desc_addr); // R9

  AST_WRAP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire && wrap_now |=> desc_addr == $past(base_addr)); // R3

  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire && !wrap_now |=> desc_addr == $past(desc_addr) + STEP_V); // R3

  AST_SEND_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> st_ready); // R1

  AST_CLEAR_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_clr |-> $past(tx_valid && tx_ready)); // R5
endmodule

bind txr_desc_ring txr_desc_ring_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .base_addr (base_addr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .tx_data   (tx_data),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .crc_clr   (crc_clr),
  .ev_tx     (ev_tx),
  .ev_txe    (ev_txe),
  .desc_addr (desc_addr),
  .wb_fire   (wb_fire),
  .wrap_now  (wrap_now),
  .st_ready  (st_ready)
);

// File: tb/txr_desc_ring_test.sv
module txr_desc_ring_test;
  localparam int AW    = 12;
  localparam int WORDS = 1 << (AW - 1);
  localparam int BASE  = 'h100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] base_addr = AW'(BASE);
  logic          idle_sel = 1'b0;
  logic [7:0]    syn1 = 8'h16;
  logic [7:0]    syn2 = 8'h32;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic          mem_gnt = 1'b1;
  logic [15:0]   mem_rdata = '0;
  logic [7:0]    tx_data;
  logic          tx_valid;
  logic          tx_ready = 1'b1;
  logic          crc_upd, crc_clr;
  logic [15:0]   crc_acc = '0;
  logic          ev_tx, ev_txe;

  always #2 clk = ~clk;

  txr_desc_ring #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .idle_sel(idle_sel),
    .syn1(syn1), .syn2(syn2), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .crc_upd(crc_upd), .crc_clr(crc_clr),
    .crc_val(crc_acc), .ev_tx(ev_tx), .ev_txe(ev_txe)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0]   mem [WORDS];
  logic [7:0]    got [256];
  int            got_n = 0;
  int            wb_cnt = 0;
  int            tx_ev = 0;
  int            txe_ev = 0;
  int            clr_cnt = 0;
  int            bad_upd = 0;
  logic [AW-1:0] last_rd = '0;
  logic [AW-1:0] first_rd = '0;
  logic          seen_rd = 1'b0;
  logic          toggle_rdy = 1'b0;
  logic          drop_arm = 1'b0;
  int            hold = 0;
  logic [15:0]   model = '0;

  function automatic logic [15:0] fold(input logic [15:0] a, input logic [7:0] b);
    return {a[14:0], a[15]} ^ {b, b};
  endfunction

  // RAM model: one-cycle read latency after grant.
  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr >> 1] <= mem_wdata;
        wb_cnt <= wb_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr >> 1];
        last_rd   <= mem_addr;
        if (!seen_rd) begin
          first_rd <= mem_addr;
          seen_rd  <= 1'b1;
        end
      end
    end
  end

  // Stream sink, check engine model, event counters.
  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        got[got_n[7:0]] <= tx_data;
        got_n <= got_n + 1;
      end
      if (ev_tx)  tx_ev  <= tx_ev + 1;
      if (ev_txe) txe_ev <= txe_ev + 1;
      if (crc_upd && !(tx_valid && tx_ready)) bad_upd <= bad_upd + 1;
      if (crc_clr) begin
        crc_acc <= '0;
        clr_cnt <= clr_cnt + 1;
      end else if (crc_upd) crc_acc <= fold(crc_acc, tx_data);
      if (toggle_rdy) tx_ready <= ~tx_ready;
      if (drop_arm && tx_valid && tx_ready) begin
        mem_gnt  <= 1'b0;
        drop_arm <= 1'b0;
        hold     <= 6;
      end else if (hold != 0) begin
        hold <= hold - 1;
        if (hold == 1) mem_gnt <= 1'b1;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [15:0] v);
    mem[a >> 1] <= v;
  endtask

  task automatic put_byte(input int a, input logic [7:0] b);
    if (a % 2 == 1) mem[a >> 1][7:0] <= b;
    else            mem[a >> 1][15:8] <= b;
  endtask

  // Status word goes last, so the descriptor turns ready only when complete.
  task automatic set_desc(input int d, input logic [15:0] stw, input int n, input int p);
    put_word(d + 2, 16'(n));
    put_word(d + 4, 16'h0);
    put_word(d + 6, 16'(p));
    @(negedge clk);
    put_word(d, stw);
  endtask

  task automatic wait_wb(input int n);
    int target;
    target = wb_cnt + n;
    while (wb_cnt < target) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_byte(input int i, input logic [7:0] e, input string tag);
    chk(got[i] == e, tag, got[i], e);
  endtask

  task automatic t_reset();
    chk(tx_valid == 1'b0, "R11 tx_valid in reset", tx_valid, 0);
    chk(!ev_tx && !ev_txe, "R11 events in reset", {ev_tx, ev_txe}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(seen_rd && first_rd == AW'(BASE), "R11 first read at base", first_rd, BASE);
    chk(got_n == 0, "R1 no byte from unready ring", got_n, 0);
    chk(last_rd == AW'(BASE), "R1 polls same descriptor", last_rd, BASE);
  endtask

  // Ready + interrupt + check bit, but last clear: plain data, success event.
  task automatic t_plain();
    int b0;
    b0 = got_n;
    for (int i = 0; i < 5; i++) put_byte('h200 + i, 8'h11 + 8'(i));
    set_desc(BASE, 16'h9400, 5, 'h200);
    wait_wb(1);
    chk(got_n - b0 == 5, "R2 R6 byte count, no tail when last=0", got_n - b0, 5);
    for (int i = 0; i < 5; i++) begin
      chk_byte(b0 + i, 8'h11 + 8'(i), "R2 data order");
      model = fold(model, 8'h11 + 8'(i));
    end
    chk(mem[BASE >> 1] == 16'h1400, "R4 status closed", mem[BASE >> 1], 16'h1400);
    chk(tx_ev == 1 && txe_ev == 0, "R7 success event", tx_ev * 16 + txe_ev, 16);
    repeat (40) @(negedge clk);
    chk(last_rd == AW'(BASE + 8), "R3 R1 advance by 8 and poll", last_rd, BASE + 8);
    chk(got_n - b0 == 5, "R1 no extra bytes while polling", got_n - b0, 5);
  endtask

  // Last + check: odd buffer start, check bytes from the engine.
  task automatic t_check();
    int b0;
    b0 = got_n;
    put_byte('h301, 8'hA1); put_byte('h302, 8'hA2); put_byte('h303, 8'hA3);
    set_desc(BASE + 8, 16'h8C00, 3, 'h301);
    wait_wb(1);
    model = fold(fold(fold(model, 8'hA1), 8'hA2), 8'hA3);
    chk(got_n - b0 == 5, "R5 data plus two check bytes", got_n - b0, 5);
    chk_byte(b0, 8'hA1, "R2 odd start byte lane");
    chk_byte(b0 + 2, 8'hA3, "R2 last data byte");
    chk_byte(b0 + 3, model[15:8], "R5 check high byte");
    chk_byte(b0 + 4, model[7:0], "R5 check low byte");
    chk(clr_cnt == 1 && crc_acc == 16'h0, "R5 engine cleared once", clr_cnt, 1);
    chk(bad_upd == 0, "R5 update only on accepted data", bad_upd, 0);
    chk(tx_ev == 1, "R7 no event when interrupt clear", tx_ev, 1);
    chk(mem[(BASE + 8) >> 1] == 16'h0C00, "R4 status closed", mem[(BASE + 8) >> 1], 16'h0C00);
  endtask

  // Last, no check, sync pair, with a stalling transmitter; wraps.
  task automatic t_sync();
    int b0;
    b0 = got_n;
    idle_sel = 1'b0;
    put_byte('h400, 8'h5A); put_byte('h401, 8'h5B);
    toggle_rdy = 1'b1;
    set_desc(BASE + 16, 16'hA800, 2, 'h400);
    wait_wb(1);
    toggle_rdy = 1'b0;
    tx_ready   = 1'b1;
    chk(got_n - b0 == 4, "R6 R10 data plus sync pair", got_n - b0, 4);
    chk_byte(b0 + 1, 8'h5B, "R10 data under stalls");
    chk_byte(b0 + 2, 8'h16, "R6 first sync");
    chk_byte(b0 + 3, 8'h32, "R6 second sync");
    chk(mem[(BASE + 16) >> 1] == 16'h2800, "R4 status closed", mem[(BASE + 16) >> 1], 16'h2800);
    repeat (30) @(negedge clk);
    chk(last_rd == AW'(BASE), "R3 wrap to base", last_rd, BASE);
  endtask

  task automatic t_idle();
    int b0;
    b0 = got_n;
    idle_sel = 1'b1;
    put_byte('h410, 8'hC1); put_byte('h411, 8'hC2);
    set_desc(BASE, 16'h8800, 2, 'h410);
    wait_wb(1);
    chk(got_n - b0 == 3, "R6 data plus idle", got_n - b0, 3);
    chk_byte(b0 + 2, 8'hFF, "R6 idle character");
    idle_sel = 1'b0;
  endtask

  // Continuous mode keeps ready; sent again on the next visit.
  task automatic t_cont();
    int b0;
    b0 = got_n;
    put_byte('h420, 8'hD1); put_byte('h421, 8'hD2); put_byte('h430, 8'hE1);
    set_desc(BASE + 16, 16'hA000, 1, 'h430);
    set_desc(BASE + 8, 16'h9200, 2, 'h420);
    wait_wb(2);
    chk(mem[(BASE + 8) >> 1] == 16'h9200, "R4 continuous keeps ready", mem[(BASE + 8) >> 1], 16'h9200);
    chk(got_n - b0 == 3, "R2 two descriptors sent", got_n - b0, 3);
    chk(tx_ev == 2, "R7 event for continuous buffer", tx_ev, 2);
    put_byte('h440, 8'hF1);
    set_desc(BASE, 16'h8000, 1, 'h440);
    wait_wb(2);
    chk(got_n - b0 == 6, "R4 resend count", got_n - b0, 6);
    chk_byte(b0 + 4, 8'hD1, "R4 resent first byte");
    chk_byte(b0 + 5, 8'hD2, "R4 resent second byte");
    chk(tx_ev == 3, "R7 event on resend", tx_ev, 3);
  endtask

  task automatic t_underrun();
    int b0;
    b0 = got_n;
    for (int i = 0; i < 4; i++) put_byte('h450 + i, 8'h71 + 8'(i));
    drop_arm = 1'b1;
    set_desc(BASE + 16, 16'hB000, 4, 'h450);
    wait_wb(1);
    chk(got_n - b0 == 1, "R8 buffer abandoned", got_n - b0, 1);
    chk(mem[(BASE + 16) >> 1] == 16'h3002, "R8 underrun status", mem[(BASE + 16) >> 1], 16'h3002);
    chk(txe_ev == 1 && tx_ev == 3, "R8 R7 error event", txe_ev, 1);
    repeat (30) @(negedge clk);
    chk(last_rd == AW'(BASE), "R8 R3 walk moves on", last_rd, BASE);
    chk(!tx_valid, "R9 stream idle after close", tx_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    @(negedge clk);
    put_word(BASE + 16, 16'h2000);
    repeat (3) @(negedge clk);
    t_reset();
    t_plain();
    t_check();
    t_sync();
    t_idle();
    t_cont();
    t_underrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule